// File: doc/BRIEF.md
# Static LCD Segment and Backplane Driver

This block turns a latched meter reading into the drive waveforms of a static 3½-digit liquid crystal panel. It takes a BCD code for each full digit, a bit for the leading "1", a sign bit, an overrange flag and a lamp-test request. It produces a common backplane square wave and one line for each segment. A segment that should be dark follows the backplane, and a lit segment runs in antiphase with it. Every segment therefore sees a pure AC voltage, and the mean DC across the glass stays near zero.

The backplane comes from a divider on the system clock. A two-state phase machine holds it: `PH_LO` drives the backplane low and `PH_HI` drives it high. The only transitions are `PH_LO -> PH_HI` and `PH_HI -> PH_LO`, and each is taken on the divider's half-period tick. The segment register loads in that same cycle, so the inputs are sampled only at backplane edges, and the panel never sees a mid-period glitch. Overrange blanks the full digits and keeps the leading "1". Lamp test lights every segment with a steady high level.

Top module: `lcd_seg_drive`

## Requirements
- R1: `backplane_o` is a 50% duty square wave with period `CLK_DIV` clocks, that is, `CLK_DIV/2` clocks high and `CLK_DIV/2` clocks low. After reset it first rises after the `CLK_DIV/2`-th clock edge.
- R2: All segment outputs change only in the clock cycle in which `backplane_o` changes.
- R3: Outside lamp test, an unlit segment output equals `backplane_o` and a lit segment output equals its inverse.
- R4: Each full digit decodes BCD 0 to 9 to standard seven-segment shapes. Within a digit, bit 0 is segment a, bit 1 is b, and so on up to bit 6, which is g. Digit k occupies `digit_seg_o[7k+6:7k]`, and digit 0 is the least significant. The lit patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R5: BCD codes 10 to 15 leave the digit fully unlit.
- R6: `half_seg_o` is a single line that drives segments b and c of the leading digit together. It is lit when `half_i` is 1.
- R7: `minus_seg_o` is lit when `neg_i` is 1 and unlit when it is 0.
- R8: When `over_i` is 1, every full digit is unlit and `half_seg_o` is lit whatever the value of `half_i`. The sign still follows `neg_i`.
- R9: When `lamp_i` is 1, every segment output is held at a constant 1 in both backplane phases, which shows 1888 with the sign. The backplane keeps toggling. Lamp test overrides overrange.
- R10: Input changes between backplane edges have no effect on the outputs until the next backplane edge.
- R11: After reset, `backplane_o` and every segment output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_i | input | DIGITS*4 | BCD codes of the full digits, digit 0 in the low nibble |
| half_i | input | 1 | Leading "1" request |
| neg_i | input | 1 | Sign bit, 1 for a negative reading |
| over_i | input | 1 | Overrange flag |
| lamp_i | input | 1 | Lamp-test request |
| backplane_o | output | 1 | Backplane square wave |
| digit_seg_o | output | DIGITS*7 | Segment lines of the full digits |
| half_seg_o | output | 1 | Shared b/c line of the leading digit |
| minus_seg_o | output | 1 | Minus-sign segment line |

## Verification
The bench checks the outputs on every falling clock edge against a model of the current backplane phase. A design that sampled its inputs between backplane edges would show a new pattern before the edge, and one that ignored the phase would put DC on lit segments. The bench drives the codes 10 to 15 to catch a decoder that shows stray segments for them. It drives overrange with the leading bit clear, which catches a design that drops the "1" or leaves the low digits visible. It drives lamp test together with overrange, which exposes a priority inversion or a lamp mode that still toggles. The spacing of backplane edges is counted from reset, which catches a divider that is off by one.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
    localparam int SEG7_W = 7;
    localparam int BCD_W  = 4;

    typedef logic [SEG7_W-1:0] seg7_t;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } bp_phase_e;
endpackage

// File: rtl/lcd_bp_timer.sv
module lcd_bp_timer #(
    parameter int CLK_DIV = 800
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    // Half-period tick: the last clock of each backplane half period.
    assign tick_o = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_bcd_decoder.sv
module lcd_bcd_decoder
    import lcd_drv_pkg::*;
(
    input  logic [BCD_W-1:0] bcd_i,
    output seg7_t            seg_o
);
    // Bit 0 = a ... bit 6 = g; codes above nine stay dark.
    always_comb begin
        case (bcd_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7D;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h6F;
            default: seg_o = 7'h00;
        endcase
    end
endmodule

// File: rtl/lcd_phase_fsm.sv
module lcd_phase_fsm
    import lcd_drv_pkg::*;
#(
    parameter int NSEG = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [NSEG-1:0] lit_i,
    input  logic            lamp_i,
    output logic            bp_o,
    output logic [NSEG-1:0] seg_o
);
    bp_phase_e state_q, state_d;
    logic [NSEG-1:0] seg_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LO: if (tick_i) state_d = PH_HI;
            PH_HI: if (tick_i) state_d = PH_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Segment levels are loaded only together with a phase change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (tick_i) begin
            if (lamp_i) begin
                seg_q <= '1;
            end else begin
                seg_q <= {NSEG{state_d == PH_HI}} ^ lit_i;
            end
        end
    end

    assign bp_o  = (state_q == PH_HI);
    assign seg_o = seg_q;
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcd_drv_pkg::*;
#(
    parameter int CLK_DIV = 800,
    parameter int DIGITS  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIGITS*4-1:0]   bcd_i,
    input  logic                  half_i,
    input  logic                  neg_i,
    input  logic                  over_i,
    input  logic                  lamp_i,
    output logic                  backplane_o,
    output logic [DIGITS*7-1:0]   digit_seg_o,
    output logic                  half_seg_o,
    output logic                  minus_seg_o
);
    localparam int DW   = DIGITS * SEG7_W;
    localparam int NSEG = DW + 2;

    logic            tick;
    logic [DW-1:0]   dec_lit;
    logic [DW-1:0]   digit_lit;
    logic [NSEG-1:0] lit_all;
    logic [NSEG-1:0] seg_all;

    lcd_bp_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        lcd_bcd_decoder u_dec (
            .bcd_i (bcd_i[k*BCD_W +: BCD_W]),
            .seg_o (dec_lit[k*SEG7_W +: SEG7_W])
        );
    end

    assign digit_lit = over_i ? '0 : dec_lit;
    assign lit_all   = {neg_i, (over_i | half_i), digit_lit};

    lcd_phase_fsm #(.NSEG(NSEG)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .lit_i  (lit_all),
        .lamp_i (lamp_i),
        .bp_o   (backplane_o),
        .seg_o  (seg_all)
    );

    assign digit_seg_o = seg_all[DW-1:0];
    assign half_seg_o  = seg_all[DW];
    assign minus_seg_o = seg_all[DW+1];
endmodule

// File: rtl/lcd_seg_drive_chk.sv
module lcd_seg_drive_chk #(
    parameter int CLK_DIV = 800,
    parameter int DIGITS  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lamp_i,
    input logic                neg_i,
    input logic                over_i,
    input logic                backplane_o,
    input logic [DIGITS*7-1:0] digit_seg_o,
    input logic                half_seg_o,
    input logic                minus_seg_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = DIGITS * 7;
    localparam int RW   = $clog2(HALF + 2);

    logic          prev_bp;
    logic [RW-1:0] run;
    logic          bp_moved;

    assign bp_moved = (backplane_o != prev_bp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_bp <= 1'b0;
            run     <= '0;
        end else begin
            prev_bp <= backplane_o;
            run     <= bp_moved ? RW'(1) : run + 1'b1;
        end
    end

    // R1
    bp_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bp_moved |-> (run == RW'(HALF)));

    // R1
    bp_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(HALF));

    // R2
    seg_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({minus_seg_o, half_seg_o, digit_seg_o}) |-> !$stable(backplane_o));

    // R7
    minus_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_moved && !$past(lamp_i)) |-> (minus_seg_o == (backplane_o ^ $past(neg_i))));

    // R9
    lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_moved && $past(lamp_i)) |-> (&{minus_seg_o, half_seg_o, digit_seg_o}));

    // R8
    over_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_moved && !$past(lamp_i) && $past(over_i)) |->
        ((digit_seg_o == {DW{backplane_o}}) && (half_seg_o == !backplane_o)));
endmodule

bind lcd_seg_drive lcd_seg_drive_chk #(.CLK_DIV(CLK_DIV), .DIGITS(DIGITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lamp_i      (lamp_i),
    .neg_i       (neg_i),
    .over_i      (over_i),
    .backplane_o (backplane_o),
    .digit_seg_o (digit_seg_o),
    .half_seg_o  (half_seg_o),
    .minus_seg_o (minus_seg_o)
);

// File: tb/lcd_seg_drive_tb.sv
module lcd_seg_drive_tb;
    localparam int CLK_DIV = 16;
    localparam int DIGITS  = 3;
    localparam int HALF    = CLK_DIV / 2;
    localparam int NOUT    = DIGITS * 7 + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIGITS*4-1:0] bcd_i = '0;
    logic half_i = 1'b0, neg_i = 1'b0, over_i = 1'b0, lamp_i = 1'b0;
    logic backplane_o, half_seg_o, minus_seg_o;
    logic [DIGITS*7-1:0] digit_seg_o;

    always #5 clk = ~clk;

    lcd_seg_drive #(.CLK_DIV(CLK_DIV), .DIGITS(DIGITS)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bcd_i       (bcd_i),
        .half_i      (half_i),
        .neg_i       (neg_i),
        .over_i      (over_i),
        .lamp_i      (lamp_i),
        .backplane_o (backplane_o),
        .digit_seg_o (digit_seg_o),
        .half_seg_o  (half_seg_o),
        .minus_seg_o (minus_seg_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [NOUT-1:0] q_lit[$];
    logic            q_lamp[$];
    string           q_tag[$];

    logic [NOUT-1:0] cur_lit  = '0;
    logic            cur_lamp = 1'b0;
    string           cur_tag  = "R11";
    logic            last_bp  = 1'b0;
    int              since    = 0;
    logic            mon_en   = 1'b0;
    event            bp_tog;

    function automatic logic [6:0] dec7(input logic [3:0] d);
        case (d)
            4'd0: return 7'h3F;  4'd1: return 7'h06;
            4'd2: return 7'h5B;  4'd3: return 7'h4F;
            4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;
            4'd8: return 7'h7F;  4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: the expectation in force advances only at backplane edges (R2, R10).
    always @(negedge clk) begin
        logic [NOUT-1:0] obs;
        logic [NOUT-1:0] exp;
        if (mon_en) begin
            since++;
            if (backplane_o !== last_bp) begin
                check("R1 half period", since, HALF);
                since   = 0;
                last_bp = backplane_o;
                if (q_lit.size() > 0) begin
                    cur_lit  = q_lit.pop_front();
                    cur_lamp = q_lamp.pop_front();
                    cur_tag  = q_tag.pop_front();
                end
                -> bp_tog;
            end
            obs = {minus_seg_o, half_seg_o, digit_seg_o};
            // R3 phase relation, R9 constant level in lamp test
            exp = cur_lamp ? {NOUT{1'b1}} : ({NOUT{backplane_o}} ^ cur_lit);
            check(cur_tag, 32'(obs), 32'(exp));
        end
    end

    task automatic apply(input logic [11:0] bcd, input logic h, input logic n,
                         input logic o, input logic l, input string tag);
        logic [NOUT-1:0] lit;
        @(negedge clk);
        #1;
        bcd_i  = bcd;
        half_i = h;
        neg_i  = n;
        over_i = o;
        lamp_i = l;
        lit = {n, (o | h),
               o ? 21'd0 : {dec7(bcd[11:8]), dec7(bcd[7:4]), dec7(bcd[3:0])}};
        q_lit.push_back(lit);
        q_lamp.push_back(l);
        q_tag.push_back(tag);
        @(bp_tog);
        @(bp_tog);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n  = 1'b1;
        since  = -1;
        mon_en = 1'b1;
        // R11 reset state is checked by the monitor before the first edge.
        apply(12'h012, 0, 0, 0, 0, "R4 digits 0,1,2");
        apply(12'h345, 0, 0, 0, 0, "R4 digits 3,4,5");
        apply(12'h678, 0, 0, 0, 0, "R4 digits 6,7,8");
        apply(12'h990, 0, 0, 0, 0, "R4 digits 9,9,0");
        apply(12'hABC, 0, 0, 0, 0, "R5 codes A,B,C");
        apply(12'hDEF, 0, 0, 0, 0, "R5 codes D,E,F");
        apply(12'h999, 1, 0, 0, 0, "R6 leading one");
        apply(12'h123, 0, 1, 0, 0, "R7 minus sign");
        apply(12'h456, 1, 1, 0, 0, "R3 sign and one");
        apply(12'h888, 0, 1, 1, 0, "R8 overrange neg");
        apply(12'h777, 0, 0, 1, 0, "R8 overrange pos");
        apply(12'h000, 0, 0, 0, 1, "R9 lamp test");
        apply(12'h5A3, 1, 0, 1, 1, "R9 lamp over overrange");
        apply(12'h000, 0, 0, 0, 0, "R3 all dark after lamp");
        apply(12'h271, 0, 0, 0, 0, "R10 mid period change");
        summary();
    end
endmodule